// File: doc/BRIEF.md
# SECDED-Protected Message RAM with Error Interrupt Wrapper

This block stores words of a communication controller's message memory with single-error-correct, double-error-detect protection. Every word written gets a set of Hamming check bits plus one overall parity bit. Every read recomputes the syndrome. A single flipped bit is repaired in the returned data. A two-bit upset is reported as uncorrectable. The default size is 1024 words of 32 bits, which is 4 KB of payload. The check bits cover only this memory; the design has no ECC and no status or enable bit for any other buffer.

Each read that finds an error raises one of two sticky raw flags: correctable or uncorrectable. Software reaches the flags through a small register port. Through that port it can:
- read the raw flags;
- read the masked status, which is the bitwise AND of the raw flags and the enables;
- set enables by writing ones to one address;
- clear enables by writing ones to another address;
- clear raw flags by writing ones to the raw-flag address.

The two interrupt lines follow the masked status. An uncorrectable error also does two things that a correctable one does not. It pulses an event line toward the protocol controller's own interrupt logic. It latches a halt line that disables the controller's transmit and receive paths until the next reset.

A diagnostic XOR mask on the write port lets test software corrupt chosen bits of the stored codeword.

Top module: `ecc_ram_irq_wrap`

## Requirements
- R1: A read of a word stored with exactly one codeword bit inverted returns the original data. Bit i of `ram_wflip` inverts codeword bit i, for any of the 39 positions.
- R2: A read of a word stored with no inverted bit returns the written data. It raises no flag.
- R3: A read that finds a single-bit error sets raw flag bit 0 (correctable). It leaves bit 1 unchanged.
- R4: A read that finds a two-bit error sets raw flag bit 1 (uncorrectable). It leaves bit 0 unchanged.
- R5: Raw flags (register address 0) stay set until software writes 1 to that bit at address 0. Bits written as 0 are kept. An error arriving in the same cycle as the clear leaves the flag set.
- R6: Reading address 1 returns the raw flags ANDed bit by bit with the enables.
- R7: Writing ones to address 2 sets those enable bits, and writing ones to address 3 clears them. Bit 0 is the correctable enable and bit 1 the uncorrectable enable. Reading address 2 or 3 returns the enables.
- R8: `irq_sec` and `irq_ded` equal raw flag AND enable for bits 0 and 1, registered one cycle after the flag or enable changes.
- R9: An uncorrectable read pulses `ctrl_ded_event` in the cycle its raw flag is set. A correctable read never raises it.
- R10: `txrx_halt` rises together with the uncorrectable raw flag. It stays high, even after the flag is cleared, until reset.
- R11: After reset, the raw flags, enables, interrupts, halt, event line and `ram_rvalid` are all 0.
- R12: A read accepted at a clock edge gives `ram_rdata` with `ram_rvalid` high after the next edge. Register reads return `reg_rdata` one edge after `reg_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ram_en | input | 1 | RAM access request |
| ram_we | input | 1 | 1 = write, 0 = read |
| ram_addr | input | ADDR_W | Word address |
| ram_wdata | input | DATA_W | Write data |
| ram_wflip | input | CW_W | Diagnostic inversion mask applied to the stored codeword |
| ram_rdata | output | DATA_W | Corrected read data |
| ram_rvalid | output | 1 | Read data valid |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 raw, 1 masked, 2 enable set, 3 enable clear |
| reg_wdata | input | 2 | Register write data (bit 0 correctable, bit 1 uncorrectable) |
| reg_rdata | output | 2 | Registered read data |
| irq_sec | output | 1 | Correctable error interrupt |
| irq_ded | output | 1 | Uncorrectable error interrupt |
| ctrl_ded_event | output | 1 | Uncorrectable error pulse toward the protocol controller |
| txrx_halt | output | 1 | Sticky transmit/receive disable |

## Verification
The bench builds the block with DATA_W = 32, which gives a 39-bit codeword, and with ADDR_W = 6. The narrow address makes random accesses revisit and overwrite the same words often. The bench places inversions on every class of codeword position: the overall parity bit, the Hamming check bits at power-of-two positions, and data positions up to the top bit. It also times a flag clear so that it lands exactly on the cycle of a new error.

// File: rtl/ecc_wrap_pkg.sv
package ecc_wrap_pkg;

  // Smallest number of Hamming check bits p with 2**p >= data + p + 1
  function automatic int ham_bits(input int dw);
    int p;
    p = 0;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  localparam int NFLAG = 2;  // bit 0 correctable, bit 1 uncorrectable

  typedef enum logic [1:0] {
    SEL_RAW    = 2'd0,
    SEL_MASKED = 2'd1,
    SEL_EN_SET = 2'd2,
    SEL_EN_CLR = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter  int DATA_W = 32,
  localparam int HAM_W  = ecc_wrap_pkg::ham_bits(DATA_W),
  localparam int CW_W   = DATA_W + HAM_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);

  // Codeword bit 0: overall parity. Bits 1..CW_W-1: Hamming positions,
  // check bits at powers of two, data in ascending order elsewhere.
  always_comb begin
    logic [CW_W-1:0] cw;
    logic            p;
    int              d;
    cw = '0;
    d  = 0;
    for (int i = 1; i < CW_W; i++) begin
      if ((i & (i - 1)) != 0) begin
        cw[i] = data_i[d];
        d++;
      end
    end
    for (int j = 0; j < HAM_W; j++) begin
      p = 1'b0;
      for (int i = 1; i < CW_W; i++) begin
        if (((i >> j) & 1) == 1) p = p ^ cw[i];
      end
      cw[1 << j] = p;
    end
    cw[0] = ^cw[CW_W-1:1];
    cw_o  = cw;
  end

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter  int DATA_W = 32,
  localparam int HAM_W  = ecc_wrap_pkg::ham_bits(DATA_W),
  localparam int CW_W   = DATA_W + HAM_W + 1
) (
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sec_o,
  output logic              ded_o
);

  always_comb begin
    logic [HAM_W-1:0] syn;
    logic [CW_W-1:0]  fix;
    logic             odd;
    int               d;
    syn = '0;
    for (int i = 1; i < CW_W; i++) begin
      if (cw_i[i]) syn = syn ^ HAM_W'(i);
    end
    odd   = ^cw_i;
    fix   = cw_i;
    sec_o = 1'b0;
    ded_o = 1'b0;
    if (odd) begin
      // odd weight: one flipped bit; syndrome 0 points at the parity bit
      if (int'(syn) < CW_W) begin
        fix[syn] = ~fix[syn];
        sec_o    = 1'b1;
      end else begin
        ded_o = 1'b1;
      end
    end else if (syn != '0) begin
      ded_o = 1'b1;
    end
    data_o = '0;
    d      = 0;
    for (int i = 1; i < CW_W; i++) begin
      if ((i & (i - 1)) != 0) begin
        data_o[d] = fix[i];
        d++;
      end
    end
  end

endmodule

// File: rtl/ecc_msg_ram.sv
module ecc_msg_ram #(
  parameter  int CW_W   = 39,
  parameter  int ADDR_W = 10,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CW_W-1:0]   wcw,
  output logic [CW_W-1:0]   rcw
);

  logic [CW_W-1:0] mem [DEPTH];

  // single port, registered read, no reset: maps onto block RAM
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wcw;
      else    rcw       <= mem[addr];
    end
  end

endmodule

// File: rtl/ecc_irq_regs.sv
module ecc_irq_regs
  import ecc_wrap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_evt,
  input  logic             ded_evt,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [NFLAG-1:0] reg_wdata,
  output logic [NFLAG-1:0] raw_o,
  output logic [NFLAG-1:0] en_o,
  output logic [NFLAG-1:0] reg_rdata,
  output logic             irq_sec,
  output logic             irq_ded,
  output logic             ctrl_ded_event,
  output logic             txrx_halt
);

  reg_sel_e         sel;
  logic [NFLAG-1:0] raw_q, en_q, clr_mask, masked;

  assign sel      = reg_sel_e'(reg_addr);
  assign clr_mask = (reg_we && sel == SEL_RAW) ? reg_wdata : '0;
  assign masked   = raw_q & en_q;
  assign raw_o    = raw_q;
  assign en_o     = en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q          <= '0;
      en_q           <= '0;
      irq_sec        <= 1'b0;
      irq_ded        <= 1'b0;
      ctrl_ded_event <= 1'b0;
      txrx_halt      <= 1'b0;
      reg_rdata      <= '0;
    end else begin
      // new events win over a simultaneous write-one-to-clear
      raw_q <= (raw_q & ~clr_mask) | {ded_evt, sec_evt};
      if (reg_we && sel == SEL_EN_SET)      en_q <= en_q | reg_wdata;
      else if (reg_we && sel == SEL_EN_CLR) en_q <= en_q & ~reg_wdata;
      irq_sec        <= masked[0];
      irq_ded        <= masked[1];
      ctrl_ded_event <= ded_evt;
      txrx_halt      <= txrx_halt | ded_evt;
      case (sel)
        SEL_RAW:    reg_rdata <= raw_q;
        SEL_MASKED: reg_rdata <= masked;
        default:    reg_rdata <= en_q;
      endcase
    end
  end

endmodule

// File: rtl/ecc_ram_irq_wrap.sv
module ecc_ram_irq_wrap
  import ecc_wrap_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int ADDR_W = 10,
  localparam int CW_W   = DATA_W + ham_bits(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ram_en,
  input  logic              ram_we,
  input  logic [ADDR_W-1:0] ram_addr,
  input  logic [DATA_W-1:0] ram_wdata,
  input  logic [CW_W-1:0]   ram_wflip,
  output logic [DATA_W-1:0] ram_rdata,
  output logic              ram_rvalid,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [1:0]        reg_wdata,
  output logic [1:0]        reg_rdata,
  output logic              irq_sec,
  output logic              irq_ded,
  output logic              ctrl_ded_event,
  output logic              txrx_halt
);

  logic [CW_W-1:0]   enc_cw, store_cw, rd_cw;
  logic [DATA_W-1:0] dec_data;
  logic              dec_sec, dec_ded;
  logic              rd_pend;
  logic              sec_evt, ded_evt;
  logic [NFLAG-1:0]  raw_flags, irq_en;

  secded_enc #(.DATA_W(DATA_W)) u_enc (
    .data_i (ram_wdata),
    .cw_o   (enc_cw)
  );

  assign store_cw = enc_cw ^ ram_wflip;

  ecc_msg_ram #(.CW_W(CW_W), .ADDR_W(ADDR_W)) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .addr (ram_addr),
    .wcw  (store_cw),
    .rcw  (rd_cw)
  );

  secded_dec #(.DATA_W(DATA_W)) u_dec (
    .cw_i   (rd_cw),
    .data_o (dec_data),
    .sec_o  (dec_sec),
    .ded_o  (dec_ded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend    <= 1'b0;
      ram_rvalid <= 1'b0;
      ram_rdata  <= '0;
      sec_evt    <= 1'b0;
      ded_evt    <= 1'b0;
    end else begin
      rd_pend    <= ram_en & ~ram_we;
      ram_rvalid <= rd_pend;
      sec_evt    <= rd_pend & dec_sec;
      ded_evt    <= rd_pend & dec_ded;
      if (rd_pend) ram_rdata <= dec_data;
    end
  end

  ecc_irq_regs u_regs (
    .clk            (clk),
    .rst            (rst),
    .sec_evt        (sec_evt),
    .ded_evt        (ded_evt),
    .reg_we         (reg_we),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .raw_o          (raw_flags),
    .en_o           (irq_en),
    .reg_rdata      (reg_rdata),
    .irq_sec        (irq_sec),
    .irq_ded        (irq_ded),
    .ctrl_ded_event (ctrl_ded_event),
    .txrx_halt      (txrx_halt)
  );

endmodule

// File: rtl/ecc_wrap_chk.sv
module ecc_wrap_chk (
  input logic       clk,
  input logic       rst,
  input logic       ram_en,
  input logic       ram_we,
  input logic       ram_rvalid,
  input logic       sec_evt,
  input logic       ded_evt,
  input logic [1:0] raw_flags,
  input logic [1:0] irq_en,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [1:0] reg_wdata,
  input logic       irq_sec,
  input logic       irq_ded,
  input logic       ctrl_ded_event,
  input logic       txrx_halt
);

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst) (ram_en && !ram_we) |-> ##2 ram_rvalid); // R12
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(sec_evt && ded_evt)); // R3
  AST_SEC_SETS_FLAG: assert property (@(posedge clk) disable iff (rst) sec_evt |=> raw_flags[0]); // R5
  AST_DED_SETS_FLAG: assert property (@(posedge clk) disable iff (rst) ded_evt |=> raw_flags[1]); // R4
  AST_IRQ_SEC_MASK: assert property (@(posedge clk) disable iff (rst) ram_en || !ram_en |=> irq_sec == $past(raw_flags[0] & irq_en[0])); // R8
  AST_IRQ_DED_MASK: assert property (@(posedge clk) disable iff (rst) ram_en || !ram_en |=> irq_ded == $past(raw_flags[1] & irq_en[1])); // R8
  AST_EN_SET: assert property (@(posedge clk) disable iff (rst) (reg_we && reg_addr == 2'd2 && reg_wdata[0]) |=> irq_en[0]); // R7
  AST_EN_CLR: assert property (@(posedge clk) disable iff (rst) (reg_we && reg_addr == 2'd3 && reg_wdata[1]) |=> !irq_en[1]); // R7
  AST_DED_PULSE: assert property (@(posedge clk) disable iff (rst) ded_evt |=> ctrl_ded_event); // R9
  AST_HALT_WITH_EVENT: assert property (@(posedge clk) disable iff (rst) ctrl_ded_event |-> txrx_halt); // R10
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst) txrx_halt |=> txrx_halt); // R10

endmodule

bind ecc_ram_irq_wrap ecc_wrap_chk u_chk (.*);

// File: tb/tb_ecc_ram_irq_wrap.sv
module tb_ecc_ram_irq_wrap;

  localparam int DW    = 32;
  localparam int AW    = 6;
  localparam int CW    = DW + 6 + 1;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ram_en = 1'b0, ram_we = 1'b0;
  logic [AW-1:0] ram_addr = '0;
  logic [DW-1:0] ram_wdata = '0;
  logic [CW-1:0] ram_wflip = '0;
  logic [DW-1:0] ram_rdata;
  logic          ram_rvalid;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic          irq_sec, irq_ded, ctrl_ded_event, txrx_halt;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ecc_ram_irq_wrap #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_wflip(ram_wflip), .ram_rdata(ram_rdata),
    .ram_rvalid(ram_rvalid), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_sec(irq_sec),
    .irq_ded(irq_ded), .ctrl_ded_event(ctrl_ded_event), .txrx_halt(txrx_halt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] flip_one(input int pos);
    return CW'(1) << pos;
  endfunction

  function automatic logic [CW-1:0] flip_two(input int p1, input int p2);
    return (CW'(1) << p1) | (CW'(1) << p2);
  endfunction

  // expected raw flag update from the number of inverted codeword bits
  function automatic logic [1:0] flag_of(input int nflip);
    if (nflip == 1) return 2'b01;
    if (nflip == 2) return 2'b10;
    return 2'b00;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [CW-1:0] f);
    @(negedge clk);
    ram_en = 1'b1; ram_we = 1'b1; ram_addr = a; ram_wdata = d; ram_wflip = f;
    @(negedge clk);
    ram_en = 1'b0; ram_we = 1'b0; ram_wflip = '0;
  endtask

  // returns just after the edge where rvalid rises (issue edge + 1)
  task automatic rd_word(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
    @(negedge clk);
    ram_en = 1'b1; ram_we = 1'b0; ram_addr = a;
    @(negedge clk);
    ram_en = 1'b0;
    @(negedge clk);
    d = ram_rdata;
    v = ram_rvalid;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [1:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] got, dat;
    logic          v;
    logic [1:0]    r, exp_raw, m;
    logic [AW-1:0] a;
    int            kind, p1, p2;
    void'($urandom(32'h1F2E3D4C));

    // reset state
    do_reset();
    chk("R11 rvalid", {63'b0, ram_rvalid}, 64'd0);
    chk("R11 irq", {62'b0, irq_sec, irq_ded}, 64'd0);
    chk("R11 halt/event", {62'b0, txrx_halt, ctrl_ded_event}, 64'd0);
    reg_rd(2'd0, r); chk("R11 raw flags", {62'b0, r}, 64'd0);
    reg_rd(2'd2, r); chk("R11 enables", {62'b0, r}, 64'd0);

    // random traffic with 0, 1 or 2 inverted bits
    exp_raw = 2'b00;
    for (int it = 0; it < 48; it++) begin
      a    = AW'($urandom % DEPTH);
      dat  = $urandom;
      kind = int'($urandom % 3);
      p1   = int'($urandom % CW);
      p2   = (p1 + 1 + int'($urandom % (CW - 1))) % CW;
      wr_word(a, dat, kind == 0 ? '0 : (kind == 1 ? flip_one(p1) : flip_two(p1, p2)));
      rd_word(a, got, v);
      chk("R12 rvalid after read", {63'b0, v}, 64'd1);
      if (kind == 0) chk("R2 clean data", {32'b0, got}, {32'b0, dat});
      if (kind == 1) chk("R1 corrected data", {32'b0, got}, {32'b0, dat});
      exp_raw = exp_raw | flag_of(kind);
      reg_rd(2'd0, r);
      chk(kind == 2 ? "R4 raw after double" : "R3 raw after read", {62'b0, r}, {62'b0, exp_raw});
      if (it % 8 == 7) begin
        m = 2'($urandom);
        reg_wr(2'd0, m);
        exp_raw = exp_raw & ~m;
        reg_rd(2'd0, r);
        chk("R5 partial clear", {62'b0, r}, {62'b0, exp_raw});
      end
    end

    // fresh state for timed checks
    do_reset();

    // enable set/clear
    reg_wr(2'd2, 2'b01); reg_rd(2'd2, r); chk("R7 set bit0", {62'b0, r}, 64'd1);
    reg_rd(2'd3, r); chk("R7 read via clear addr", {62'b0, r}, 64'd1);
    reg_wr(2'd2, 2'b10); reg_rd(2'd2, r); chk("R7 set bit1", {62'b0, r}, 64'd3);
    reg_wr(2'd3, 2'b01); reg_rd(2'd2, r); chk("R7 clear bit0", {62'b0, r}, 64'd2);
    reg_wr(2'd3, 2'b10); reg_rd(2'd2, r); chk("R7 clear bit1", {62'b0, r}, 64'd0);
    reg_wr(2'd2, 2'b01);

    // single error on the overall parity bit, timed interrupt
    wr_word(AW'(5), 32'hA5A5_0F0F, flip_one(0));
    rd_word(AW'(5), got, v);
    chk("R1 parity-bit flip data", {32'b0, got}, 64'hA5A5_0F0F);
    @(negedge clk);
    chk("R9 no event on correctable", {63'b0, ctrl_ded_event}, 64'd0);
    chk("R8 irq_sec not yet", {63'b0, irq_sec}, 64'd0);
    chk("R10 no halt on correctable", {63'b0, txrx_halt}, 64'd0);
    @(negedge clk);
    chk("R8 irq_sec one cycle after flag", {63'b0, irq_sec}, 64'd1);
    reg_rd(2'd1, r); chk("R6 masked sec", {62'b0, r}, 64'd1);

    // top codeword bit single error
    wr_word(AW'(6), 32'h1234_5678, flip_one(CW - 1));
    rd_word(AW'(6), got, v);
    chk("R1 top-bit flip data", {32'b0, got}, 64'h1234_5678);

    // double error: event pulse and halt
    wr_word(AW'(7), 32'hDEAD_BEEF, flip_two(1, 3));
    rd_word(AW'(7), got, v);
    chk("R10 halt low before flag", {63'b0, txrx_halt}, 64'd0);
    @(negedge clk);
    chk("R9 event pulse", {63'b0, ctrl_ded_event}, 64'd1);
    chk("R10 halt rises", {63'b0, txrx_halt}, 64'd1);
    @(negedge clk);
    chk("R9 event one cycle", {63'b0, ctrl_ded_event}, 64'd0);
    chk("R8 irq_ded masked off", {63'b0, irq_ded}, 64'd0);
    reg_rd(2'd0, r); chk("R4 both flags", {62'b0, r}, 64'd3);
    reg_rd(2'd1, r); chk("R6 masked only sec", {62'b0, r}, 64'd1);
    reg_wr(2'd2, 2'b10);
    @(negedge clk);
    chk("R8 irq_ded after enable", {63'b0, irq_ded}, 64'd1);

    // halt survives flag clear and disable
    reg_wr(2'd0, 2'b10);
    reg_wr(2'd3, 2'b11);
    reg_rd(2'd0, r); chk("R5 clear ded only", {62'b0, r}, 64'd1);
    chk("R10 halt held", {63'b0, txrx_halt}, 64'd1);
    do_reset();
    chk("R11 halt cleared by reset", {63'b0, txrx_halt}, 64'd0);

    // clear lands on the same edge as a new correctable error
    wr_word(AW'(9), 32'h0BAD_F00D, flip_one(17));
    reg_wr(2'd0, 2'b01);
    @(negedge clk);
    ram_en = 1'b1; ram_we = 1'b0; ram_addr = AW'(9);
    @(negedge clk);
    ram_en = 1'b0;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 2'b01;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    reg_rd(2'd0, r); chk("R5 set wins over clear", {62'b0, r}, 64'd1);
    reg_wr(2'd0, 2'b01);
    reg_rd(2'd0, r); chk("R5 later clear", {62'b0, r}, 64'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule